// File: doc/BRIEF.md
# Multi-Polynomial Byte-Wise CRC Generator

This block keeps a running cyclic redundancy check over a stream of bytes. Each byte presented with its valid strobe is folded into the CRC register within one clock cycle. A stream may be of any length. The current CRC value is always readable on the output port.

A configuration input picks one of three generator polynomials: one 8-bit and two 16-bit. A second configuration input picks the bit order of the protected link.

- For a most-significant-bit-first link, the register shifts left and uses the plain polynomial.
- For a least-significant-bit-first link, the register shifts right, uses the bit-reversed polynomial, and takes bit 0 of each byte first.

A clear input zeroes the register before a new message. Changing the polynomial selection also zeroes it, so a result never mixes two polynomials.

Top module: `crc_calc_unit`

## Requirements
- R1: After reset is released, `crcOut` reads 16'h0000.
- R2: In a cycle where `dataValid` is low and neither `clear` nor a polynomial change occurs, `crcOut` keeps its value.
- R3: `clear` high at a clock edge makes `crcOut` 16'h0000 after that edge, and a byte strobed in the same cycle is discarded.
- R4: A change of `polySel` from one cycle to the next zeroes the register, and a byte strobed in that cycle is discarded. A change of `lsbFirst` alone leaves `crcOut` unchanged.
- R5: `polySel` = 0 selects x^8+x^2+x+1 (0x07). Only `crcOut[7:0]` carries the CRC, and `crcOut[15:8]` reads zero.
- R6: `polySel` = 1 selects x^16+x^15+x^2+1 (0x8005).
- R7: `polySel` = 2 selects x^16+x^12+x^5+1 (0x1021).
- R8: `lsbFirst` = 0 processes `dataIn[7]` first into a left-shifting register. `lsbFirst` = 1 processes `dataIn[0]` first into a right-shifting register with the reversed polynomial (0xE0, 0xA001, 0x8408 respectively).
- R9: `polySel` = 3 behaves exactly as `polySel` = 0.
- R10: A byte strobed at a clock edge is reflected in `crcOut` after that same edge, and bytes may be strobed on consecutive cycles.
- R11: With a zero start, the ASCII string "123456789" gives 0xF4 (poly 0, MSB-first), 0xFEE8 (poly 1, MSB-first), 0x31C3 (poly 2, MSB-first), 0xBB3D (poly 1, LSB-first) and 0x2189 (poly 2, LSB-first).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Zero the CRC register at the next edge |
| polySel | input | 2 | Polynomial choice: 0/3 8-bit, 1 and 2 16-bit |
| lsbFirst | input | 1 | 1 = LSB-first link order, 0 = MSB-first |
| dataIn | input | 8 | Byte to fold into the CRC |
| dataValid | input | 1 | Strobe qualifying `dataIn` |
| crcOut | output | 16 | Current CRC register value |

## Verification
The hardest situation to reach is a polynomial change that lands in the same cycle as a valid byte. It must both clear the register and drop the byte, and that only shows when the register already holds a non-zero 16-bit value. The bench first accumulates bytes under a 16-bit polynomial. It then switches to the 8-bit polynomial while holding a byte valid, and checks that the upper byte has gone to zero and the dropped byte left no trace. Toggling the bit order in mid-stream is paired with an idle cycle, so the held value can be compared directly.

// File: rtl/crc_calc_pkg.sv
package crc_calc_pkg;

  localparam int BYTE_W = 8;
  localparam int CRC_W  = 16;

  typedef enum logic [1:0] {
    POLY_NARROW = 2'd0,
    POLY_WIDE_A = 2'd1,
    POLY_WIDE_B = 2'd2,
    POLY_ALIAS  = 2'd3
  } polyKindT;

  // Strobes and settings handed from control to datapath each cycle.
  typedef struct packed {
    logic              clearCrc;
    logic              foldByte;
    logic              narrow;
    logic              reflect;
    logic [CRC_W-1:0]  taps;
    logic [BYTE_W-1:0] data;
  } crcStrobeT;

  // Reverse the low w bits of v; bits at and above w come out zero.
  function automatic logic [CRC_W-1:0] reverseLow(input logic [CRC_W-1:0] v, input int w);
    logic [CRC_W-1:0] r;
    r = '0;
    for (int i = 0; i < CRC_W; i++) begin
      if (i < w) r[w-1-i] = v[i];
    end
    return r;
  endfunction

  function automatic logic [CRC_W-1:0] plainTaps(input polyKindT kind);
    logic [CRC_W-1:0] t;
    case (kind)
      POLY_WIDE_A: t = 16'h8005;
      POLY_WIDE_B: t = 16'h1021;
      default:     t = 16'h0007;
    endcase
    return t;
  endfunction

  function automatic logic isNarrow(input polyKindT kind);
    return (kind == POLY_NARROW) || (kind == POLY_ALIAS);
  endfunction

endpackage

// File: rtl/crc_calc_ctrl.sv
module crc_calc_ctrl
  import crc_calc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              clear,
  input  logic [1:0]        polySel,
  input  logic              lsbFirst,
  input  logic [BYTE_W-1:0] dataIn,
  input  logic              dataValid,
  output crcStrobeT         stb
);

  logic [1:0]       prevSel;
  polyKindT         kind;
  logic             selMoved;
  logic             narrowNow;
  logic [CRC_W-1:0] plain;
  logic [CRC_W-1:0] chosen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevSel <= 2'd0;
    else       prevSel <= polySel;
  end

  assign kind      = polyKindT'(polySel);
  assign selMoved  = (polySel != prevSel);
  assign narrowNow = isNarrow(kind);
  assign plain     = plainTaps(kind);

  always_comb begin
    if (lsbFirst) chosen = reverseLow(plain, narrowNow ? BYTE_W : CRC_W);
    else          chosen = plain;
  end

  always_comb begin
    stb.clearCrc = clear | selMoved;
    stb.foldByte = dataValid & ~(clear | selMoved);
    stb.narrow   = narrowNow;
    stb.reflect  = lsbFirst;
    stb.taps     = chosen;
    stb.data     = dataIn;
  end

  // A selection change must never let a byte through in the same cycle.
  AST_SEL_BLOCKS_FOLD: assert property (@(posedge clk) disable iff (!rstN)
    (polySel != $past(polySel)) |-> !stb.foldByte); // R4

endmodule

// File: rtl/crc_calc_datapath.sv
module crc_calc_datapath
  import crc_calc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  crcStrobeT        stb,
  output logic [CRC_W-1:0] crcQ
);

  localparam int          STEPS      = BYTE_W;
  localparam logic [CRC_W-1:0] NARROW_MASK = CRC_W'((1 << BYTE_W) - 1);
  localparam logic [CRC_W-1:0] WIDE_MASK   = {CRC_W{1'b1}};

  logic [CRC_W-1:0] stage [STEPS+1];
  logic [CRC_W-1:0] keepMask;
  logic             topIdxNarrow;

  assign keepMask     = stb.narrow ? NARROW_MASK : WIDE_MASK;
  assign topIdxNarrow = stb.narrow;
  assign stage[0]     = crcQ;

  // One unrolled bit step per data bit.
  for (genvar g = 0; g < STEPS; g++) begin : gStep
    logic inBit;
    logic topBit;
    logic fb;
    logic [CRC_W-1:0] shifted;

    assign inBit  = stb.reflect ? stb.data[g] : stb.data[BYTE_W-1-g];
    assign topBit = topIdxNarrow ? stage[g][BYTE_W-1] : stage[g][CRC_W-1];

    always_comb begin
      if (stb.reflect) begin
        fb      = stage[g][0] ^ inBit;
        shifted = stage[g] >> 1;
      end else begin
        fb      = topBit ^ inBit;
        shifted = (stage[g] << 1) & keepMask;
      end
    end

    assign stage[g+1] = fb ? (shifted ^ stb.taps) : shifted;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             crcQ <= '0;
    else if (stb.clearCrc) crcQ <= '0;
    else if (stb.foldByte) crcQ <= stage[STEPS] & keepMask;
  end

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rstN)
    stb.clearCrc |=> (crcQ == '0)); // R3

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.clearCrc && !stb.foldByte) |=> $stable(crcQ)); // R2

  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    stb.narrow |=> (crcQ[CRC_W-1:BYTE_W] == '0)); // R5

endmodule

// File: rtl/crc_calc_unit.sv
module crc_calc_unit
  import crc_calc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        clear,
  input  logic [1:0]  polySel,
  input  logic        lsbFirst,
  input  logic [7:0]  dataIn,
  input  logic        dataValid,
  output logic [15:0] crcOut
);

  crcStrobeT stb;

  crc_calc_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .clear     (clear),
    .polySel   (polySel),
    .lsbFirst  (lsbFirst),
    .dataIn    (dataIn),
    .dataValid (dataValid),
    .stb       (stb)
  );

  crc_calc_datapath uPath (
    .clk  (clk),
    .rstN (rstN),
    .stb  (stb),
    .crcQ (crcOut)
  );

  AST_POLY_SWITCH_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (polySel != $past(polySel)) |=> (crcOut == 16'h0000)); // R4

endmodule

// File: tb/crc_calc_unit_test.sv
module crc_calc_unit_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clear = 1'b0;
  logic [1:0]  polySel = 2'd0;
  logic        lsbFirst = 1'b0;
  logic [7:0]  dataIn = 8'h00;
  logic        dataValid = 1'b0;
  logic [15:0] crcOut;

  int total = 0;
  int bad = 0;
  logic [15:0] model = 16'h0000;
  bit done = 1'b0;

  crc_calc_unit uut (
    .clk(clk), .rstN(rstN), .clear(clear), .polySel(polySel),
    .lsbFirst(lsbFirst), .dataIn(dataIn), .dataValid(dataValid), .crcOut(crcOut)
  );

  always #5 clk = ~clk;

  // {polySel, lsbFirst, expected CRC of "123456789"}
  localparam logic [18:0] VEC [5] = '{
    {2'd0, 1'b0, 16'h00F4},
    {2'd1, 1'b0, 16'hFEE8},
    {2'd2, 1'b0, 16'h31C3},
    {2'd1, 1'b1, 16'hBB3D},
    {2'd2, 1'b1, 16'h2189}
  };

  // Bit-serial reference, built from the requirement text.
  function automatic logic [15:0] refStep(input logic [15:0] c, input logic [7:0] b,
                                          input logic [1:0] sel, input logic lsb);
    logic [15:0] p, rp, m;
    int w;
    logic fb;
    if (sel == 2'd1)      begin p = 16'h8005; rp = 16'hA001; w = 16; end
    else if (sel == 2'd2) begin p = 16'h1021; rp = 16'h8408; w = 16; end
    else                  begin p = 16'h0007; rp = 16'h00E0; w = 8;  end
    m = (w == 8) ? 16'h00FF : 16'hFFFF;
    if (lsb) begin
      for (int i = 0; i < 8; i++) begin
        fb = c[0] ^ b[i];
        c = c >> 1;
        if (fb) c = c ^ rp;
      end
    end else begin
      for (int i = 7; i >= 0; i--) begin
        fb = c[w-1] ^ b[i];
        c = (c << 1) & m;
        if (fb) c = c ^ p;
      end
    end
    return c & m;
  endfunction

  task automatic check(input string req, input logic [15:0] exp);
    total++;
    if (crcOut !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, crcOut, exp);
    end
  endtask

  // Inputs change at the falling edge; result is read one falling edge later.
  task automatic pushByte(input logic [7:0] b, input string req);
    dataIn = b;
    dataValid = 1'b1;
    @(negedge clk);
    model = refStep(model, b, polySel, lsbFirst);
    check(req, model);
  endtask

  task automatic restart(input logic [1:0] sel, input logic lsb);
    dataValid = 1'b0;
    polySel = sel;
    lsbFirst = lsb;
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    model = 16'h0000;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        bad++;
        total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] held;
    logic [7:0]  lfsr;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset value", 16'h0000);

    // Table walk: known check values for "123456789".
    for (int v = 0; v < 5; v++) begin
      restart(VEC[v][18:17], VEC[v][16]);
      for (int k = 1; k <= 9; k++) pushByte(8'h30 + 8'(k), "R10 back-to-back byte vs model");
      dataValid = 1'b0;
      check("R11 check string (R5 R6 R7 R8)", VEC[v][15:0]);
    end

    // Alias selection behaves as the 8-bit polynomial (R9).
    restart(2'd3, 1'b0);
    for (int k = 1; k <= 9; k++) pushByte(8'h30 + 8'(k), "R9 alias byte");
    dataValid = 1'b0;
    check("R9 alias check string", 16'h00F4);

    // Sweep every polynomial and order with pseudo-random bytes.
    lfsr = 8'hA5;
    for (int s = 0; s < 4; s++) begin
      for (int o = 0; o < 2; o++) begin
        restart(2'(s), 1'(o));
        for (int n = 0; n < 40; n++) begin
          lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
          pushByte(lfsr, "R8 sweep byte");
          if (s == 0 || s == 3) begin
            total++;
            if (crcOut[15:8] !== 8'h00) begin
              bad++;
              $display("FAIL R5 upper byte: got %h expected 00", crcOut[15:8]);
            end
          end
        end
      end
    end
    dataValid = 1'b0;

    // R2: idle cycles hold the value.
    restart(2'd2, 1'b0);
    pushByte(8'h5A, "R7 single byte");
    pushByte(8'hC3, "R7 single byte");
    dataValid = 1'b0;
    held = crcOut;
    repeat (4) @(negedge clk);
    check("R2 idle hold", held);

    // R4: bit-order change alone keeps the value.
    lsbFirst = 1'b1;
    @(negedge clk);
    check("R4 order change holds", held);
    lsbFirst = 1'b0;
    @(negedge clk);

    // R3: clear together with a valid byte gives zero and drops the byte.
    dataIn = 8'hFF;
    dataValid = 1'b1;
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    dataValid = 1'b0;
    check("R3 clear drops byte", 16'h0000);
    model = 16'h0000;
    pushByte(8'h01, "R3 restart after clear");
    dataValid = 1'b0;
    check("R7 byte 01 from zero", 16'h1021);

    // R4: polynomial switch with a byte present clears and drops it.
    restart(2'd1, 1'b0);
    pushByte(8'h9C, "R6 byte");
    pushByte(8'h17, "R6 byte");
    dataIn = 8'h77;
    dataValid = 1'b1;
    polySel = 2'd0;
    @(negedge clk);
    check("R4 switch clears", 16'h0000);
    model = 16'h0000;
    pushByte(8'h01, "R5 first byte after switch");
    dataValid = 1'b0;
    check("R5 byte 01 narrow", 16'h0007);

    // Reset in mid-stream returns to zero.
    restart(2'd2, 1'b1);
    pushByte(8'h42, "R8 byte");
    dataValid = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset mid-stream", 16'h0000);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule